// File: doc/BRIEF.md
# Slave Response Compliance Monitor

This block passively observes the slave side of a pipelined on-chip bus and follows a compact protocol state machine. It looks only at the slave select, the two-bit transfer kind, the ready handshake and the two-bit response code. Address, data, burst shape and direction are left to other logic. The block has no outputs that reach the bus, so it can sit beside any single slave in simulation or in silicon.

Each clock the monitor classifies what the slave returned against the transfer it is answering. It moves between an idle state, a completed-transfer state, a wait state and a state for the first half of a two-cycle error-class response. Any illegal slave behaviour sends it into a dedicated error state. That state holds until reset and raises a flag. The current state is also exported as a 3-bit code. Downstream transaction matchers and coverage counters can then work on protocol states and not on raw signals.

Transfer kinds are encoded 00 = idle, 01 = busy, 10 = non-sequential, 11 = sequential. Response 00 is OKAY, and every other value is an error-class response. State codes are 0 = idle, 1 = transfer done, 2 = waiting, 3 = first response cycle, 7 = error. Codes 4 to 6 are never produced.

Top module: `ahb_resp_monitor`

## Requirements
- R1: While rst_n is low, mon_state reads 0 and error_flag reads 0. The same holds on the first cycle after release.
- R2: In state 0 or 1 with bus_sel low, the next state is 0 whatever the transfer kind, ready and response are.
- R3: In state 0 or 1 with bus_sel high and kind idle (00) or busy (01), the result is as follows. Ready high with response 00 leads to state 0. Ready low, or any response other than 00, leads to state 7.
- R4: In state 0 or 1 with bus_sel high and kind 10 or 11, ready high with response 00 leads to state 1.
- R5: In state 0 or 1 with bus_sel high and kind 10 or 11, ready low with response 00 leads to state 2. In state 2, ready low with response 00 stays in 2, and ready high with response 00 leads to state 1.
- R6: Ready high with a response other than 00 leads to state 7. This applies in state 2, and in state 0 or 1 with bus_sel high and kind 10 or 11.
- R7: Ready low with a response other than 00 leads to state 3 and the code is remembered. This applies in state 2, and in state 0 or 1 with bus_sel high and kind 10 or 11. In state 3, ready high with the remembered code leads to state 0, and any other input pattern leads to state 7.
- R8: State 7 is left only by reset. error_flag is high exactly when mon_state is 7, and mon_state never takes the values 4, 5 or 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| bus_sel | input | 1 | Slave select seen on the bus |
| bus_trans | input | 2 | Transfer kind: 00 idle, 01 busy, 10 non-sequential, 11 sequential |
| bus_ready | input | 1 | Transfer-done handshake from the slave |
| bus_resp | input | 2 | Slave response code, 00 = OKAY |
| mon_state | output | 3 | Encoded protocol state: 0 idle, 1 done, 2 wait, 3 first response cycle, 7 error |
| error_flag | output | 1 | High while the monitor sits in the error state |

## Verification
The bench builds the block with its default widths: a 2-bit transfer kind, a 2-bit response and a 3-bit state code. With these widths all sixteen combinations of transfer kind and response are reachable, together with both select and ready levels, from each of the four legal states. Random stimulus is weighted towards OKAY answers and selected transfers, so that long legal runs through the wait and two-cycle response paths occur before an error ends a segment. Each segment then starts from a fresh reset. Directed cases cover the edges: a mismatched second response cycle, a busy transfer held off by ready low, and an error-class answer given in a single cycle.

// File: rtl/ahb_rmon_pkg.sv
package ahb_rmon_pkg;
  localparam int TRANS_W = 2;
  localparam int RESP_W  = 2;
  localparam int STATE_W = 3;

  localparam logic [TRANS_W-1:0] TK_IDLE = 2'b00;
  localparam logic [TRANS_W-1:0] TK_BUSY = 2'b01;
  localparam logic [RESP_W-1:0]  RC_OKAY = 2'b00;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE = 3'd0,
    ST_DONE = 3'd1,
    ST_WAIT = 3'd2,
    ST_RSP1 = 3'd3,
    ST_ERR  = 3'd7
  } mon_state_e;
endpackage

// File: rtl/ahb_rmon_classify.sv
module ahb_rmon_classify
  import ahb_rmon_pkg::*;
#(
  parameter int TW = TRANS_W,
  parameter int RW = RESP_W
) (
  input  logic          sel,
  input  logic [TW-1:0] trans,
  input  logic [RW-1:0] resp,
  output logic          sel_ctl,
  output logic          sel_act,
  output logic          resp_ok
);
  logic ctl_kind;

  always_comb begin
    ctl_kind = (trans == TW'(TK_IDLE)) || (trans == TW'(TK_BUSY));
    sel_ctl  = sel && ctl_kind;
    sel_act  = sel && !ctl_kind;
    resp_ok  = (resp == RW'(RC_OKAY));
  end
endmodule

// File: rtl/ahb_rmon_hold.sv
module ahb_rmon_hold #(
  parameter int RW = ahb_rmon_pkg::RESP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [RW-1:0] d,
  output logic [RW-1:0] q
);
  logic [RW-1:0] q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else if (load) begin
      q_r <= d;
    end
  end

  assign q = q_r;

  // R7: remembered code only changes when a first response cycle is entered
  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q_r));
endmodule

// File: rtl/ahb_rmon_fsm.sv
module ahb_rmon_fsm
  import ahb_rmon_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_ctl,
  input  logic       sel_act,
  input  logic       ready,
  input  logic       resp_ok,
  input  logic       resp_match,
  output mon_state_e state,
  output logic       load_code,
  output logic       err_flag
);
  mon_state_e state_q, state_d;
  logic       err_q;
  logic       err_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (sel_act) begin
          if (ready) state_d = resp_ok ? ST_DONE : ST_ERR;
          else       state_d = resp_ok ? ST_WAIT : ST_RSP1;
        end else if (sel_ctl) begin
          state_d = (ready && resp_ok) ? ST_IDLE : ST_ERR;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_WAIT: begin
        if (ready) state_d = resp_ok ? ST_DONE : ST_ERR;
        else       state_d = resp_ok ? ST_WAIT : ST_RSP1;
      end
      ST_RSP1: state_d = (ready && resp_match) ? ST_IDLE : ST_ERR;
      ST_ERR:  state_d = ST_ERR;
      default: state_d = ST_ERR;
    endcase
    load_code = (state_d == ST_RSP1);
    err_d     = err_q || (state_d == ST_ERR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  assign state    = state_q;
  assign err_flag = err_q;

  // R8: error state is left only through reset
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ERR) |=> (state_q == ST_ERR));

  // R3: idle or busy transfer must get a zero-wait OKAY answer
  assert_ctl_answer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_IDLE || state_q == ST_DONE) && sel_ctl && !(ready && resp_ok))
      |=> (state_q == ST_ERR));

  // R6: a wait may only end with an OKAY answer on a single cycle
  assert_wait_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && ready && !resp_ok) |=> (state_q == ST_ERR));

  // R5: wait with OKAY and ready low keeps waiting
  assert_wait_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !ready && resp_ok) |=> (state_q == ST_WAIT));

  // R2: deselected bus from a decode state returns to idle
  assert_desel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_IDLE || state_q == ST_DONE) && !sel_ctl && !sel_act)
      |=> (state_q == ST_IDLE));
endmodule

// File: rtl/ahb_resp_monitor.sv
module ahb_resp_monitor
  import ahb_rmon_pkg::*;
#(
  parameter int TW = TRANS_W,
  parameter int RW = RESP_W,
  parameter int SW = STATE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic [TW-1:0] bus_trans,
  input  logic          bus_ready,
  input  logic [RW-1:0] bus_resp,
  output logic [SW-1:0] mon_state,
  output logic          error_flag
);
  logic          sel_ctl, sel_act, resp_ok;
  logic          load_code;
  logic [RW-1:0] held_code;
  logic          resp_match;
  mon_state_e    state;

  ahb_rmon_classify #(.TW(TW), .RW(RW)) u_class (
    .sel     (bus_sel),
    .trans   (bus_trans),
    .resp    (bus_resp),
    .sel_ctl (sel_ctl),
    .sel_act (sel_act),
    .resp_ok (resp_ok)
  );

  ahb_rmon_hold #(.RW(RW)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load_code),
    .d     (bus_resp),
    .q     (held_code)
  );

  assign resp_match = (bus_resp == held_code);

  ahb_rmon_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_ctl    (sel_ctl),
    .sel_act    (sel_act),
    .ready      (bus_ready),
    .resp_ok    (resp_ok),
    .resp_match (resp_match),
    .state      (state),
    .load_code  (load_code),
    .err_flag   (error_flag)
  );

  assign mon_state = SW'(state);

  // R8: flag register and state register agree
  assert_flag_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    error_flag == (mon_state == SW'(ST_ERR)));

  // R8: reserved codes never appear
  assert_code_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mon_state != SW'(4) && mon_state != SW'(5) && mon_state != SW'(6));

  // R7: second response cycle with the same code completes to idle
  assert_rsp_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_state == SW'(ST_RSP1) && bus_ready && bus_resp == held_code)
      |=> (mon_state == SW'(ST_IDLE)));
endmodule

// File: tb/ahb_resp_monitor_test.sv
module ahb_resp_monitor_test;
  logic       clk;
  logic       rst_n;
  logic       bus_sel;
  logic [1:0] bus_trans;
  logic       bus_ready;
  logic [1:0] bus_resp;
  logic [2:0] mon_state;
  logic       error_flag;

  int checks;
  int failures;
  logic [2:0] exp_state;
  logic [1:0] exp_hold;

  ahb_resp_monitor uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_trans  (bus_trans),
    .bus_ready  (bus_ready),
    .bus_resp   (bus_resp),
    .mon_state  (mon_state),
    .error_flag (error_flag)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [2:0] model_next(input logic [2:0] s, input logic sel,
      input logic [1:0] tk, input logic rdy, input logic [1:0] rc, input logic [1:0] hold);
    logic ok, act, ctl;
    ok  = (rc == 2'b00);
    act = sel && tk[1];
    ctl = sel && !tk[1];
    case (s)
      3'd0, 3'd1: begin
        if (act)      return rdy ? (ok ? 3'd1 : 3'd7) : (ok ? 3'd2 : 3'd3);
        else if (ctl) return (rdy && ok) ? 3'd0 : 3'd7;
        else          return 3'd0;
      end
      3'd2:    return rdy ? (ok ? 3'd1 : 3'd7) : (ok ? 3'd2 : 3'd3);
      3'd3:    return (rdy && rc == hold) ? 3'd0 : 3'd7;
      default: return 3'd7;
    endcase
  endfunction

  task automatic check(input string tag);
    checks++;
    if (mon_state !== exp_state || error_flag !== (exp_state == 3'd7)) begin
      failures++;
      $display("FAIL %s: state=%0d flag=%0b expected state=%0d flag=%0b",
               tag, mon_state, error_flag, exp_state, exp_state == 3'd7);
    end
  endtask

  task automatic step(input logic sel, input logic [1:0] tk, input logic rdy,
                      input logic [1:0] rc, input string tag);
    logic [2:0] nxt;
    bus_sel = sel; bus_trans = tk; bus_ready = rdy; bus_resp = rc;
    nxt = model_next(exp_state, sel, tk, rdy, rc, exp_hold);
    if (nxt == 3'd3) exp_hold = rc;
    exp_state = nxt;
    @(negedge clk);
    check(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    bus_sel = 1'b0; bus_trans = 2'b00; bus_ready = 1'b1; bus_resp = 2'b00;
    exp_state = 3'd0;
    exp_hold  = 2'b00;
    @(negedge clk);
    check("R1 reset held");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release");
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog: state=%0d expected run end", mon_state);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0;
    failures = 0;
    void'($urandom(32'd7731));
    rst_n = 1'b0;
    bus_sel = 1'b0; bus_trans = 2'b00; bus_ready = 1'b1; bus_resp = 2'b00;
    @(negedge clk);
    do_reset();

    step(1'b0, 2'b10, 1'b0, 2'b01, "R2 deselected ignores bad answer");
    step(1'b1, 2'b00, 1'b1, 2'b00, "R3 idle kind OKAY");
    step(1'b1, 2'b10, 1'b1, 2'b00, "R4 non-seq done");
    step(1'b1, 2'b11, 1'b1, 2'b00, "R4 seq done from done");
    step(1'b0, 2'b01, 1'b0, 2'b11, "R2 deselected from done");
    step(1'b1, 2'b11, 1'b0, 2'b00, "R5 enter wait");
    step(1'b1, 2'b00, 1'b0, 2'b00, "R5 stay wait");
    step(1'b1, 2'b00, 1'b1, 2'b00, "R5 wait completes");
    step(1'b1, 2'b01, 1'b1, 2'b00, "R3 busy kind OKAY");
    step(1'b1, 2'b10, 1'b0, 2'b01, "R7 first response cycle");
    step(1'b0, 2'b00, 1'b1, 2'b01, "R7 second cycle same code");
    step(1'b1, 2'b10, 1'b0, 2'b00, "R5 wait again");
    step(1'b1, 2'b10, 1'b0, 2'b10, "R7 first cycle from wait");
    step(1'b1, 2'b10, 1'b1, 2'b01, "R7 mismatched second code");
    step(1'b1, 2'b10, 1'b1, 2'b00, "R8 sticky error");
    step(1'b0, 2'b00, 1'b1, 2'b00, "R8 sticky error idle bus");

    do_reset();
    step(1'b1, 2'b01, 1'b0, 2'b00, "R3 busy held off");
    do_reset();
    step(1'b1, 2'b00, 1'b1, 2'b11, "R3 idle kind bad code");
    do_reset();
    step(1'b1, 2'b10, 1'b0, 2'b00, "R5 enter wait");
    step(1'b1, 2'b10, 1'b1, 2'b11, "R6 wait ends with error code");
    do_reset();
    step(1'b1, 2'b11, 1'b1, 2'b01, "R6 single-cycle error code");
    do_reset();
    step(1'b1, 2'b11, 1'b0, 2'b11, "R7 first response cycle");
    step(1'b1, 2'b11, 1'b0, 2'b11, "R7 ready low on second cycle");

    for (int seg = 0; seg < 60; seg++) begin
      do_reset();
      for (int c = 0; c < 30; c++) begin
        logic       s, r;
        logic [1:0] t, rc;
        s  = ($urandom % 10) < 8;
        t  = 2'($urandom);
        r  = ($urandom % 3) != 0;
        rc = (($urandom % 10) < 8) ? 2'b00 : 2'($urandom);
        if (exp_state == 3'd3 && ($urandom % 2) == 1) begin
          r = 1'b1;
          rc = exp_hold;
        end
        step(s, t, r, rc, "R8 random run");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule